// File: doc/BRIEF.md
# Serial Receiver with Valid/Ready Word Output

This block takes an asynchronous serial line and turns each received frame into a parallel word. It offers that word on a valid/ready stream port. The line idles high. A frame is one low start bit, then `W` data bits sent least significant bit first, then one high stop bit. The bit period is set by the live `prescale` input. One bit lasts `8 * prescale` clock cycles, so `prescale` should equal the clock frequency divided by eight times the baud rate. Software may change `prescale` between frames without resetting the block.

The block is built around a four-state controller:

- **IDLE** waits for a falling edge on the synchronized line. That edge is the transition IDLE→START.
- **START** waits half a bit and checks the line again. If the line is still low, it moves START→DATA. If the line has gone back high, it treats the edge as a glitch and moves START→IDLE.
- **DATA** samples each bit once, at its middle. After the last bit it moves DATA→STOP.
- **STOP** samples the stop bit at its middle and then always moves STOP→IDLE.

A good stop bit loads the word into the output register. If the previous word has not been taken yet, the new word replaces it and the overrun flag pulses. A low stop bit discards the word and pulses the frame-error flag. The synchronous reset clears everything.

Top module: `serial_rx_stream`

## Requirements
- R1: After synchronous reset, `rx_valid`, `busy`, `frame_err` and `overrun_err` are all 0.
- R2: A frame is a low start bit, `W` data bits with bit 0 sent first, and a high stop bit. A frame with a good stop bit presents its data bits on `rx_data` with `rx_valid` = 1.
- R3: One bit lasts `8 * prescale` clock cycles, and each bit is sampled once, at its middle. A new `prescale` value applied between frames takes effect on the next frame.
- R4: If the line returns high before the middle of the start bit, the block returns to IDLE. In that case no word is produced and `busy` ends up 0.
- R5: While `rx_valid` = 1 and `rx_ready` = 0, `rx_valid` stays 1 and `rx_data` stays unchanged, unless an overrun replaces the word. A word is consumed only in a cycle where both `rx_valid` and `rx_ready` are 1.
- R6: A stop bit sampled low produces a one-cycle pulse on `frame_err`. The word is discarded and `rx_valid` is not raised.
- R7: A good frame that completes while the previous word is unconsumed produces a one-cycle pulse on `overrun_err`. The new word replaces the old one on `rx_data`.
- R8: `busy` is 1 from detection of the start edge until the stop-bit sample, and 0 in IDLE.
- R9: The word width is the parameter `W`, which defaults to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxd | input | 1 | Serial line, idles high |
| prescale | input | 16 | Clock cycles per eighth of a bit |
| rx_data | output | W | Received word |
| rx_valid | output | 1 | Word available |
| rx_ready | input | 1 | Consumer accepts the word |
| busy | output | 1 | A frame is in progress |
| frame_err | output | 1 | One-cycle pulse: bad stop bit |
| overrun_err | output | 1 | One-cycle pulse: unconsumed word overwritten |

## Verification
The hardest case to reach is an overrun. It needs two complete frames to arrive while the consumer holds `rx_ready` low the whole time. The stimulus therefore drops `rx_ready` first and sends one frame. It confirms that the first word is held steady through idle time, then sends a second frame. It then checks for exactly one overrun pulse and for the second word in the output register before releasing `rx_ready`. Start-bit glitches shorter than half a bit are also driven, to exercise the START→IDLE path.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } srx_state_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RESET_VAL;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= RESET_VAL;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/srx_timer.sv
module srx_timer #(
    parameter int CW = 19
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/serial_rx_stream.sv
module serial_rx_stream
    import srx_pkg::*;
#(
    parameter int W  = 8,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rxd,
    input  logic [PW-1:0] prescale,
    output logic [W-1:0]  rx_data,
    output logic          rx_valid,
    input  logic          rx_ready,
    output logic          busy,
    output logic          frame_err,
    output logic          overrun_err
);
    localparam int CW = PW + 3;
    localparam int IW = (W > 1) ? $clog2(W) : 1;
    localparam logic [IW-1:0] LAST_BIT = IW'(W - 1);

    srx_state_t state, state_nx;

    logic          rx_s, rx_prev, fall;
    logic          expired, load;
    logic [CW-1:0] load_val, half_bit, full_bit;
    logic [IW-1:0] bit_idx;
    logic [W-1:0]  shreg;
    logic          finish;

    srx_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst(rst), .din(rxd), .dout(rx_s)
    );

    srx_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val), .expired(expired)
    );

    assign half_bit = {1'b0, prescale, 2'b00} - 1'b1;
    assign full_bit = {prescale, 3'b000} - 1'b1;
    assign fall     = rx_prev && !rx_s;
    assign finish   = (state == ST_STOP) && expired;

    assign load = ((state == ST_IDLE) && fall) ||
                  ((state == ST_START) && expired && !rx_s) ||
                  ((state == ST_DATA) && expired);
    assign load_val = (state == ST_IDLE) ? half_bit : full_bit;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (fall) state_nx = ST_START;
            ST_START: if (expired) state_nx = rx_s ? ST_IDLE : ST_DATA;
            ST_DATA:  if (expired && bit_idx == LAST_BIT) state_nx = ST_STOP;
            ST_STOP:  if (expired) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // datapath: edge history, bit counter, shift register
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_prev <= 1'b1;
            bit_idx <= '0;
            shreg   <= '0;
        end else begin
            rx_prev <= rx_s;
            if (state == ST_START) begin
                bit_idx <= '0;
            end else if (state == ST_DATA && expired) begin
                shreg   <= {rx_s, shreg[W-1:1]};
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data     <= '0;
            rx_valid    <= 1'b0;
            frame_err   <= 1'b0;
            overrun_err <= 1'b0;
        end else begin
            frame_err   <= finish && !rx_s;
            overrun_err <= finish && rx_s && rx_valid && !rx_ready;
            if (finish && rx_s) begin
                rx_data  <= shreg;
                rx_valid <= 1'b1;
            end else if (rx_ready) begin
                rx_valid <= 1'b0;
            end
        end
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] rx_data,
    input logic         rx_valid,
    input logic         rx_ready,
    input logic         busy,
    input logic         frame_err,
    input logic         overrun_err
);
    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (rst)
        rx_valid && !rx_ready |=> rx_valid); // R5
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
        rx_valid && !rx_ready |=> $stable(rx_data) || overrun_err); // R5
    AST_FERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !frame_err); // R6
    AST_FERR_NO_WORD: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> !overrun_err); // R6
    AST_OVR_PULSE: assert property (@(posedge clk) disable iff (rst)
        overrun_err |=> !overrun_err); // R7
    AST_OVR_VALID: assert property (@(posedge clk) disable iff (rst)
        overrun_err |-> rx_valid); // R7
    AST_WORD_FROM_FRAME: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_valid) |-> $past(busy)); // R8
    AST_ERR_FROM_FRAME: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> $past(busy)); // R8
endmodule

bind serial_rx_stream srx_checker #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .busy(busy), .frame_err(frame_err),
    .overrun_err(overrun_err)
);

// File: tb/sim_serial_rx_stream.sv
module sim_serial_rx_stream;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rxd = 1'b1;
    logic [15:0]  prescale = 16'd2;
    logic [W-1:0] rx_data;
    logic         rx_valid;
    logic         rx_ready = 1'b1;
    logic         busy;
    logic         frame_err;
    logic         overrun_err;

    int n_checks = 0;
    int n_fail   = 0;
    int ferr_cnt = 0;
    int ovr_cnt  = 0;
    logic [W-1:0] exp_q[$];

    always #2 clk = ~clk;

    serial_rx_stream #(.W(W)) u0 (
        .clk(clk), .rst(rst), .rxd(rxd), .prescale(prescale),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .busy(busy), .frame_err(frame_err), .overrun_err(overrun_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [W-1:0] d, input bit stop_ok, input bit expect_word);
        int bitc;
        bitc = 8 * int'(prescale);
        if (expect_word) exp_q.push_back(d);
        rxd = 1'b0;
        wait_cyc(bitc);
        for (int i = 0; i < W; i++) begin
            rxd = d[i];
            wait_cyc(bitc);
        end
        rxd = stop_ok;
        wait_cyc(bitc);
        rxd = 1'b1;
        wait_cyc(bitc);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (frame_err)   ferr_cnt++;
            if (overrun_err) ovr_cnt++;
            if (rx_valid && rx_ready) begin
                if (exp_q.size() == 0) begin
                    check("R2 unexpected word", {24'd0, rx_data}, 32'hFFFF_FFFF);
                end else begin
                    check("R2 word", {24'd0, rx_data}, {24'd0, exp_q.pop_front()});
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        wait_cyc(4);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", rx_valid, 0);
        check("R1 busy after reset", busy, 0);
        check("R1 errors after reset", {frame_err, overrun_err}, 0);
        check("R9 width", $bits(rx_data), 8);

        // R2: varied patterns at prescale 2, with busy sampled mid-frame (R8)
        fork
            send_frame(8'hA5, 1'b1, 1'b1);
            begin wait_cyc(40); check("R8 busy mid-frame", busy, 1); end
        join
        check("R8 busy idle", busy, 0);
        send_frame(8'h01, 1'b1, 1'b1);
        send_frame(8'h80, 1'b1, 1'b1);

        // R3: run-time prescale changes
        prescale = 16'd3;
        wait_cyc(4);
        send_frame(8'h3C, 1'b1, 1'b1);
        prescale = 16'd1;
        wait_cyc(4);
        send_frame(8'hFF, 1'b1, 1'b1);
        send_frame(8'h00, 1'b1, 1'b1);
        prescale = 16'd2;
        wait_cyc(4);

        // R4: short start glitch
        rxd = 1'b0;
        wait_cyc(3);
        rxd = 1'b1;
        wait_cyc(30);
        check("R4 busy after glitch", busy, 0);
        check("R4 no word after glitch", rx_valid, 0);
        send_frame(8'h5A, 1'b1, 1'b1);

        // R6: bad stop bit
        send_frame(8'hC3, 1'b0, 1'b0);
        wait_cyc(4);
        check("R6 frame error pulses", ferr_cnt, 1);
        check("R6 word discarded", rx_valid, 0);

        // R5 / R7: hold then overrun
        rx_ready = 1'b0;
        send_frame(8'h11, 1'b1, 1'b0);
        wait_cyc(40);
        check("R5 valid held", rx_valid, 1);
        check("R5 data held", {24'd0, rx_data}, 32'h11);
        send_frame(8'h99, 1'b1, 1'b0);
        check("R7 overrun pulses", ovr_cnt, 1);
        check("R7 word replaced", {24'd0, rx_data}, 32'h99);
        check("R7 still valid", rx_valid, 1);
        exp_q.push_back(8'h99);
        rx_ready = 1'b1;
        wait_cyc(4);
        check("R5 consumed", rx_valid, 0);
        check("R2 all words seen", exp_q.size(), 0);
        check("R6 no extra frame errors", ferr_cnt, 1);
        finish_run();
    end
endmodule